// File: doc/BRIEF.md
# Coherent Split-Read Counter Shadow

This block gives a bus-side read port onto a 32-bit free-running counter that lives in a timer clock domain. The timer clock has no fixed relationship to the bus clock. The counter is Gray-encoded and registered in the timer domain. It then crosses into the bus domain through a synchronizer chain and is decoded back to binary. As a result, every value the bus side sees is one that the counter really held, and a value caught in the middle of an increment is never seen.

Software on a 16-bit bus reads the counter in two steps. It reads the lower half first at byte offset 0x8, then the upper half at offset 0xA. The lower-half read returns bits 15:0 of the synchronized sample. In the same cycle it captures bits 31:16 of that same sample into a shadow register. The later upper-half read returns the shadow, not the live counter, so the two halves always belong to one sample. A full-width read at offset 0x8 returns the synchronized value directly and leaves the shadow untouched.

Top module: `crs_counter_shadow`

## Requirements
- R1: After the bus-domain reset, the shadow holds zero: a 16-bit read at offset 0xA returns 0, and with `rd_en` low `rd_data` is 0.
- R2: A read with `rd_wide`=1 (32-bit access) at offset 0x8 returns the full counter value once the counter has been held still for at least 10 bus cycles.
- R3: A read with `rd_wide`=0 (16-bit access) at offset 0x8 returns counter bits 15:0 on `rd_data[15:0]`, with `rd_data[31:16]` zero.
- R4: That same 16-bit read at offset 0x8 loads bits 31:16 of the same sample into the shadow, at the clock edge that ends the read cycle.
- R5: A 16-bit read at offset 0xA returns the shadow on `rd_data[15:0]` (upper bits zero), even if the live counter has changed since the lower-half read.
- R6: A 32-bit read leaves the shadow unchanged.
- R7: A read at any other offset, or a 32-bit read at 0xA, returns 0 and does not change the shadow. Only a 16-bit read at 0x8 updates it.
- R8: With the counter running, each lower-then-upper pair forms a value the counter really held. Successive pairs never decrease, and none is more than 64 counts behind the live counter.
- R9: `rd_data` depends only on the current request and the registered state. It is valid in the same cycle that `rd_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tmr_clk | input | 1 | Timer clock, asynchronous to bus_clk |
| tmr_rst_n | input | 1 | Timer-domain reset, active low, asynchronous assert |
| tmr_count | input | 32 | Free-running counter value, timer domain |
| bus_clk | input | 1 | Bus interface clock |
| bus_rst_n | input | 1 | Bus-domain reset, active low, asynchronous assert |
| rd_en | input | 1 | Read strobe, one bus cycle per access |
| rd_ofs | input | 8 | Byte offset of the access |
| rd_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| rd_data | output | 32 | Read data, valid while rd_en is high |

## Verification
The assertions are written on the bus side only. They assume that the synchronized snapshot reflects a counter that moves by at most one step per timer clock. They also assume that each read strobe carries a stable offset and size during its cycle. The bench respects this. It changes the counter either by free-running increments or by loading a new value while counting is stopped, and after a load it waits at least ten bus cycles before reading. Read requests are driven on the falling bus-clock edge and held for exactly one cycle.

// File: rtl/crs_pkg.sv
package crs_pkg;

  localparam int unsigned CNT_W  = 32;
  localparam int unsigned HALF_W = CNT_W / 2;
  localparam int unsigned OFS_W  = 8;

  function automatic logic [CNT_W-1:0] bin_to_gray(input logic [CNT_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [CNT_W-1:0] gray_to_bin(input logic [CNT_W-1:0] g);
    logic [CNT_W-1:0] b;
    b[CNT_W-1] = g[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

  typedef enum logic [1:0] {
    REQ_NONE,
    REQ_LOW,
    REQ_HIGH,
    REQ_FULL
  } req_kind_e;

endpackage

// File: rtl/crs_rst_sync.sv
module crs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n = chain_q[STAGES-1];

endmodule

// File: rtl/crs_gray_launch.sv
module crs_gray_launch
  import crs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] bin_in,
  output logic [CNT_W-1:0] gray_out
);

  logic [CNT_W-1:0] gray_d;
  logic [CNT_W-1:0] gray_q;

  always_comb begin
    gray_d = bin_to_gray(bin_in);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gray_q <= '0;
    end else begin
      gray_q <= gray_d;
    end
  end

  assign gray_out = gray_q;

endmodule

// File: rtl/crs_gray_capture.sv
module crs_gray_capture
  import crs_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] gray_in,
  output logic [CNT_W-1:0] snap_out
);

  logic [CNT_W-1:0] sync_q [SYNC_STAGES];
  logic [CNT_W-1:0] sync_d [SYNC_STAGES];
  logic [CNT_W-1:0] snap_d;
  logic [CNT_W-1:0] snap_q;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_comb sync_d[g] = gray_in;
    end else begin : g_next
      always_comb sync_d[g] = sync_q[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q[g] <= '0;
      end else begin
        sync_q[g] <= sync_d[g];
      end
    end
  end

  always_comb begin
    snap_d = gray_to_bin(sync_q[SYNC_STAGES-1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
    end else begin
      snap_q <= snap_d;
    end
  end

  assign snap_out = snap_q;

endmodule

// File: rtl/crs_read_port.sv
module crs_read_port
  import crs_pkg::*;
#(
  parameter int unsigned LO_OFS = 8,
  parameter int unsigned HI_OFS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [OFS_W-1:0]  rd_ofs,
  input  logic              rd_wide,
  input  logic [CNT_W-1:0]  snap,
  output logic [CNT_W-1:0]  rd_data,
  output logic [HALF_W-1:0] shadow
);

  localparam logic [OFS_W-1:0] LO_ADDR = OFS_W'(LO_OFS);
  localparam logic [OFS_W-1:0] HI_ADDR = OFS_W'(HI_OFS);

  req_kind_e         kind;
  logic              shadow_en;
  logic [HALF_W-1:0] shadow_d;
  logic [HALF_W-1:0] shadow_q;

  always_comb begin
    kind = REQ_NONE;
    if (rd_en) begin
      if (rd_wide && rd_ofs == LO_ADDR) begin
        kind = REQ_FULL;
      end else if (!rd_wide && rd_ofs == LO_ADDR) begin
        kind = REQ_LOW;
      end else if (!rd_wide && rd_ofs == HI_ADDR) begin
        kind = REQ_HIGH;
      end
    end
  end

  always_comb begin
    shadow_en = (kind == REQ_LOW);
    shadow_d  = snap[CNT_W-1:HALF_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
    end else if (shadow_en) begin
      shadow_q <= shadow_d;
    end
  end

  always_comb begin
    unique case (kind)
      REQ_FULL: rd_data = snap;
      REQ_LOW:  rd_data = {{HALF_W{1'b0}}, snap[HALF_W-1:0]};
      REQ_HIGH: rd_data = {{HALF_W{1'b0}}, shadow_q};
      default:  rd_data = '0;
    endcase
  end

  assign shadow = shadow_q;

endmodule

// File: rtl/crs_counter_shadow.sv
module crs_counter_shadow
  import crs_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned LO_OFS      = 8,
  parameter int unsigned HI_OFS      = 10
) (
  input  logic             tmr_clk,
  input  logic             tmr_rst_n,
  input  logic [CNT_W-1:0] tmr_count,
  input  logic             bus_clk,
  input  logic             bus_rst_n,
  input  logic             rd_en,
  input  logic [OFS_W-1:0] rd_ofs,
  input  logic             rd_wide,
  output logic [CNT_W-1:0] rd_data
);

  logic              tmr_rst_sn;
  logic              bus_rst_sn;
  logic [CNT_W-1:0]  gray_tmr;
  logic [CNT_W-1:0]  snap_val;
  logic [HALF_W-1:0] shadow_val;

  crs_rst_sync #(.STAGES(2)) u_tmr_rst (
    .clk    (tmr_clk),
    .arst_n (tmr_rst_n),
    .rst_n  (tmr_rst_sn)
  );

  crs_rst_sync #(.STAGES(2)) u_bus_rst (
    .clk    (bus_clk),
    .arst_n (bus_rst_n),
    .rst_n  (bus_rst_sn)
  );

  crs_gray_launch u_launch (
    .clk      (tmr_clk),
    .rst_n    (tmr_rst_sn),
    .bin_in   (tmr_count),
    .gray_out (gray_tmr)
  );

  crs_gray_capture #(.SYNC_STAGES(SYNC_STAGES)) u_capture (
    .clk      (bus_clk),
    .rst_n    (bus_rst_sn),
    .gray_in  (gray_tmr),
    .snap_out (snap_val)
  );

  crs_read_port #(.LO_OFS(LO_OFS), .HI_OFS(HI_OFS)) u_port (
    .clk     (bus_clk),
    .rst_n   (bus_rst_sn),
    .rd_en   (rd_en),
    .rd_ofs  (rd_ofs),
    .rd_wide (rd_wide),
    .snap    (snap_val),
    .rd_data (rd_data),
    .shadow  (shadow_val)
  );

endmodule

// File: rtl/crs_counter_shadow_chk.sv
module crs_counter_shadow_chk
  import crs_pkg::*;
#(
  parameter int unsigned LO_OFS = 8,
  parameter int unsigned HI_OFS = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic [OFS_W-1:0]  rd_ofs,
  input logic              rd_wide,
  input logic [CNT_W-1:0]  snap,
  input logic [HALF_W-1:0] shadow,
  input logic [CNT_W-1:0]  rd_data
);

  localparam logic [OFS_W-1:0] LO_ADDR = OFS_W'(LO_OFS);
  localparam logic [OFS_W-1:0] HI_ADDR = OFS_W'(HI_OFS);

  logic lo_req;
  logic hi_req;
  logic full_req;

  assign lo_req   = rd_en && !rd_wide && rd_ofs == LO_ADDR;
  assign hi_req   = rd_en && !rd_wide && rd_ofs == HI_ADDR;
  assign full_req = rd_en &&  rd_wide && rd_ofs == LO_ADDR;

  // R4: lower-half read captures upper bits of the same sample
  p_low_loads_shadow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lo_req |=> shadow == $past(snap[CNT_W-1:HALF_W]));

  // R6, R7: only the lower-half read may change the shadow
  p_shadow_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_req |=> $stable(shadow));

  // R5: upper-half read returns the shadow
  p_high_from_shadow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hi_req |-> rd_data == {{HALF_W{1'b0}}, shadow});

  // R2: full read returns the synchronized sample
  p_full_direct_r2: assert property (@(posedge clk) disable iff (!rst_n)
    full_req |-> rd_data == snap);

  // R3: lower-half read, upper lanes zero
  p_low_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lo_req |-> rd_data == {{HALF_W{1'b0}}, snap[HALF_W-1:0]});

  // R1, R7: no matching request gives zero data
  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(lo_req || hi_req || full_req) |-> rd_data == '0);

endmodule

bind crs_counter_shadow crs_counter_shadow_chk #(
  .LO_OFS (LO_OFS),
  .HI_OFS (HI_OFS)
) u_chk (
  .clk     (bus_clk),
  .rst_n   (bus_rst_sn),
  .rd_en   (rd_en),
  .rd_ofs  (rd_ofs),
  .rd_wide (rd_wide),
  .snap    (snap_val),
  .shadow  (shadow_val),
  .rd_data (rd_data)
);

// File: tb/crs_counter_shadow_bench.sv
module crs_counter_shadow_bench;

  logic        bclk = 1'b0;
  logic        tclk = 1'b0;
  logic        bus_rst_n = 1'b0;
  logic        tmr_rst_n = 1'b0;
  logic [31:0] tcnt = '0;
  logic        run = 1'b0;
  logic        ld = 1'b0;
  logic [31:0] ld_val = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_ofs = '0;
  logic        rd_wide = 1'b0;
  logic [31:0] rd_data;

  int checks = 0;
  int failures = 0;

  always #10 bclk = ~bclk;
  always #3.5 tclk = ~tclk;

  always @(posedge tclk) begin
    if (ld) tcnt <= ld_val;
    else if (run) tcnt <= tcnt + 32'd1;
  end

  crs_counter_shadow u_crs_counter_shadow (
    .tmr_clk   (tclk),
    .tmr_rst_n (tmr_rst_n),
    .tmr_count (tcnt),
    .bus_clk   (bclk),
    .bus_rst_n (bus_rst_n),
    .rd_en     (rd_en),
    .rd_ofs    (rd_ofs),
    .rd_wide   (rd_wide),
    .rd_data   (rd_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic wide, input logic [7:0] ofs, output logic [31:0] d);
    @(negedge bclk);
    rd_en = 1'b1; rd_wide = wide; rd_ofs = ofs;
    #2 d = rd_data;
    @(negedge bclk);
    rd_en = 1'b0; rd_wide = 1'b0; rd_ofs = '0;
  endtask

  task automatic load_count(input logic [31:0] v);
    run = 1'b0;
    ld_val = v;
    ld = 1'b1;
    @(posedge tclk);
    #1 ld = 1'b0;
    repeat (12) @(posedge bclk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    repeat (3) @(negedge bclk);
    bus_rst_n = 1'b1; tmr_rst_n = 1'b1;
    repeat (6) @(negedge bclk);
    #2 check("R1 idle data", rd_data, 32'h0);
    do_read(1'b0, 8'h0A, d);
    check("R1 shadow zero", d, 32'h0);
  endtask

  task automatic t_full_frozen();
    logic [31:0] d;
    load_count(32'hDEAD_BEEF);
    do_read(1'b1, 8'h08, d);
    check("R2 full read", d, 32'hDEAD_BEEF);
    load_count(32'h1234_5678);
    do_read(1'b1, 8'h08, d);
    check("R2 full read 2", d, 32'h1234_5678);
    do_read(1'b0, 8'h0A, d);
    check("R6 shadow kept after full reads", d, 32'h0);
  endtask

  task automatic t_split_tear();
    logic [31:0] d;
    load_count(32'h0000_FFFF);
    do_read(1'b0, 8'h08, d);
    check("R3 low half", d, 32'h0000_FFFF);
    load_count(32'h0001_0000);
    do_read(1'b0, 8'h0A, d);
    check("R5 high from shadow not live", d, 32'h0000_0000);
    do_read(1'b1, 8'h08, d);
    check("R2 full read live", d, 32'h0001_0000);
    do_read(1'b0, 8'h0A, d);
    check("R6 full read left shadow", d, 32'h0000_0000);
    do_read(1'b0, 8'h08, d);
    check("R3 low half zero", d, 32'h0000_0000);
    do_read(1'b0, 8'h0A, d);
    check("R4 shadow loaded by low read", d, 32'h0000_0001);
  endtask

  task automatic t_other_offsets();
    logic [31:0] d;
    load_count(32'hABCD_9876);
    do_read(1'b0, 8'h04, d);
    check("R7 16-bit other offset", d, 32'h0);
    do_read(1'b1, 8'h0A, d);
    check("R7 32-bit at 0xA", d, 32'h0);
    do_read(1'b1, 8'h00, d);
    check("R7 32-bit at 0x0", d, 32'h0);
    do_read(1'b0, 8'h0A, d);
    check("R7 shadow unchanged", d, 32'h0000_0001);
    do_read(1'b0, 8'h08, d);
    check("R9 same-cycle low data", d, 32'h0000_9876);
    do_read(1'b0, 8'h0A, d);
    check("R4 shadow new upper", d, 32'h0000_ABCD);
  endtask

  task automatic t_running();
    logic [31:0] lo;
    logic [31:0] hi;
    logic [31:0] val;
    logic [31:0] cur;
    logic [31:0] prev;
    load_count(32'h0000_F800);
    prev = 32'h0000_F800;
    run = 1'b1;
    for (int i = 0; i < 40; i++) begin
      repeat (7 + (i % 5)) @(posedge bclk);
      do_read(1'b0, 8'h08, lo);
      repeat (i % 3) @(posedge bclk);
      do_read(1'b0, 8'h0A, hi);
      cur = tcnt;
      val = {hi[15:0], lo[15:0]};
      checks++;
      if (val < prev || val > cur || (cur - val) > 32'd64 ||
          lo[31:16] != 16'h0 || hi[31:16] != 16'h0) begin
        failures++;
        $display("FAIL R8 pair %0d actual=%h expected range %h..%h", i, val, prev, cur);
      end
      prev = val;
    end
    run = 1'b0;
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_full_frozen();
        t_split_tear();
        t_other_offsets();
        t_running();
      end
      begin
        repeat (100000) @(posedge bclk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule